// File: doc/BRIEF.md
# Boundary Scan Test Access Port

This block is a serial test port for a memory device, built to the usual four-wire boundary scan protocol. A test clock, a mode-select line and a serial data input drive a sixteen-state controller. That controller moves bits through one of four shift paths, and the active instruction picks the path. The four paths are a 3-bit instruction register, a single-bit bypass stage, a 32-bit identification register and a 109-bit boundary register that sits over the device's pin ring.

A board tester uses the port in three ways. It reads the fixed identity word, which is the default instruction after any reset. It samples or preloads the pin ring. It drives the pins from the boundary register's update latch. One extra instruction samples the ring while the pin drivers are switched off. Inputs are taken on the rising test-clock edge. The serial output, and its enable, move only on the falling edge.

Top module: `bscan_tap`

## Requirements
- R1: `tms` and `tdi` are taken on the rising `tck` edge, and `tdo` changes only on the falling `tck` edge.
- R2: `tdo_oe` is 1 only while the controller is in Shift-IR or Shift-DR. It is 0 in all other states and after power-on reset.
- R3: Five consecutive rising edges with `tms` high bring the controller to Test-Logic-Reset from any state.
- R4: Entering Test-Logic-Reset, including at power-on, makes IDCODE (code 001) the active instruction.
- R5: In Capture-IR the instruction shift register is loaded with 001, so the first three bits shifted out are 1, 0, 0.
- R6: Bits shifted through Shift-IR change the active instruction only at Update-IR. Pause-IR and the Exit states leave it as it was.
- R7: Each path shifts toward its least significant bit. `tdo` presents bit 0, and `tdi` enters the top bit. The path lengths are 1 (bypass), 32 (identity) and 109 (boundary).
- R8: The bypass stage captures 0 in Capture-DR. BYPASS (111) and the unassigned codes 011, 101 and 110 all select it.
- R9: Under IDCODE, Capture-DR loads the identity register with the `ID_CODE` parameter.
- R10: Under EXTEST (000), SAMPLE/PRELOAD (100) and SAMPLE-HIGHZ (010), Capture-DR loads boundary bit i with `pin_in[i]`.
- R11: `ring_upd` loads the boundary register on the falling edge in Update-DR when the boundary path is selected. It holds its value at every other time, and under every other instruction.
- R12: `ring_oe` is 0 exactly while SAMPLE-HIGHZ is active. `ring_extest` is 1 exactly while EXTEST is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| tms | input | 1 | Mode select, taken on the rising edge |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_oe | output | 1 | Output enable for `tdo` (0 means high-Z) |
| pin_in | input | 109 | Pin ring values captured into the boundary register |
| ring_upd | output | 109 | Update latch that drives the pin ring under EXTEST |
| ring_oe | output | 1 | Pin-ring driver enable, forced low under SAMPLE-HIGHZ |
| ring_extest | output | 1 | High while the update latch owns the pin ring |

## Verification
A bit presented on `tdo` is due at the falling edge that follows the rising edge on which the controller entered the shift state. The bench drives `tms` and `tdi` one nanosecond after each falling edge and reads `tdo` in the same low phase. It also reads `tdo` again just after the next rising edge, to confirm the value did not move. A new instruction, and the ring flags that follow from it, are due at the falling edge inside Update-IR. `ring_upd` is due at the falling edge inside Update-DR. Each scan task returns one full cycle after those edges, in Run-Test-Idle, before it compares. For the reset test, the bench waits for the falling edge after the fifth high `tms` before it checks the restored instruction.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  localparam int IR_LEN = 3;

  typedef enum logic [3:0] {
    S_TLR      = 4'h0,
    S_RTI      = 4'h1,
    S_SEL_DR   = 4'h2,
    S_CAP_DR   = 4'h3,
    S_SH_DR    = 4'h4,
    S_EX1_DR   = 4'h5,
    S_PAUSE_DR = 4'h6,
    S_EX2_DR   = 4'h7,
    S_UPD_DR   = 4'h8,
    S_SEL_IR   = 4'h9,
    S_CAP_IR   = 4'hA,
    S_SH_IR    = 4'hB,
    S_EX1_IR   = 4'hC,
    S_PAUSE_IR = 4'hD,
    S_EX2_IR   = 4'hE,
    S_UPD_IR   = 4'hF
  } tap_state_e;

  typedef enum logic [1:0] {
    PATH_BYP = 2'd0,
    PATH_ID  = 2'd1,
    PATH_BSR = 2'd2
  } dr_path_e;

  localparam logic [IR_LEN-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_LEN-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_LEN-1:0] OP_SAMPLEZ = 3'b010;
  localparam logic [IR_LEN-1:0] OP_SAMPLE  = 3'b100;
  localparam logic [IR_LEN-1:0] OP_BYPASS  = 3'b111;
  localparam logic [IR_LEN-1:0] IR_CAPTURE = 3'b001;

endpackage

// File: rtl/bscan_fsm.sv
module bscan_fsm
  import bscan_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      S_TLR:      state_nx = tms ? S_TLR     : S_RTI;
      S_RTI:      state_nx = tms ? S_SEL_DR  : S_RTI;
      S_SEL_DR:   state_nx = tms ? S_SEL_IR  : S_CAP_DR;
      S_CAP_DR:   state_nx = tms ? S_EX1_DR  : S_SH_DR;
      S_SH_DR:    state_nx = tms ? S_EX1_DR  : S_SH_DR;
      S_EX1_DR:   state_nx = tms ? S_UPD_DR  : S_PAUSE_DR;
      S_PAUSE_DR: state_nx = tms ? S_EX2_DR  : S_PAUSE_DR;
      S_EX2_DR:   state_nx = tms ? S_UPD_DR  : S_SH_DR;
      S_UPD_DR:   state_nx = tms ? S_SEL_DR  : S_RTI;
      S_SEL_IR:   state_nx = tms ? S_TLR     : S_CAP_IR;
      S_CAP_IR:   state_nx = tms ? S_EX1_IR  : S_SH_IR;
      S_SH_IR:    state_nx = tms ? S_EX1_IR  : S_SH_IR;
      S_EX1_IR:   state_nx = tms ? S_UPD_IR  : S_PAUSE_IR;
      S_PAUSE_IR: state_nx = tms ? S_EX2_IR  : S_PAUSE_IR;
      S_EX2_IR:   state_nx = tms ? S_UPD_IR  : S_SH_IR;
      S_UPD_IR:   state_nx = tms ? S_SEL_DR  : S_RTI;
      default:    state_nx = S_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= S_TLR;
    else        state <= state_nx;
  end

  // Run length of high tms, saturating at five; used by the R3 check only.
  logic [2:0] tms_run;
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)              tms_run <= 3'd0;
    else if (!tms)           tms_run <= 3'd0;
    else if (tms_run != 3'd5) tms_run <= tms_run + 3'd1;
  end

  // R3: five high tms edges always end in Test-Logic-Reset
  p_tms_reset_r3: assert property (@(posedge tck) disable iff (!rst_n)
    (tms_run == 3'd5) |-> (state == S_TLR));

endmodule

// File: rtl/bscan_ir.sv
module bscan_ir
  import bscan_pkg::*;
(
  input  logic              tck,
  input  logic              rst_n,
  input  tap_state_e        state,
  input  logic              tdi,
  output logic              ir_lsb,
  output logic [IR_LEN-1:0] instr,
  output dr_path_e          path,
  output logic              op_extest,
  output logic              op_samplez
);

  logic [IR_LEN-1:0] ir_sh, ir_sh_nx;
  logic              cap_en, sh_en, upd_en, rst_en;

  assign cap_en = (state == S_CAP_IR);
  assign sh_en  = (state == S_SH_IR);
  assign upd_en = (state == S_UPD_IR);
  assign rst_en = (state == S_TLR);

  always_comb begin
    ir_sh_nx = ir_sh;
    if (cap_en)     ir_sh_nx = IR_CAPTURE;
    else if (sh_en) ir_sh_nx = {tdi, ir_sh[IR_LEN-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) ir_sh <= IR_CAPTURE;
    else        ir_sh <= ir_sh_nx;
  end

  assign ir_lsb = ir_sh[0];

  // Active instruction moves on the falling edge, in Update-IR or reset state.
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)      instr <= OP_IDCODE;
    else if (rst_en) instr <= OP_IDCODE;
    else if (upd_en) instr <= ir_sh;
  end

  always_comb begin
    path       = PATH_BYP;
    op_extest  = 1'b0;
    op_samplez = 1'b0;
    unique case (instr)
      OP_EXTEST:  begin path = PATH_BSR; op_extest = 1'b1; end
      OP_IDCODE:  path = PATH_ID;
      OP_SAMPLEZ: begin path = PATH_BSR; op_samplez = 1'b1; end
      OP_SAMPLE:  path = PATH_BSR;
      default:    path = PATH_BYP;
    endcase
  end

  // R5: capture pattern
  p_ir_capture_r5: assert property (@(posedge tck) disable iff (!rst_n)
    (state == S_CAP_IR) |=> (ir_sh[1:0] == 2'b01));

  // R6: instruction only moves during Update-IR or Test-Logic-Reset
  p_instr_hold_r6: assert property (@(posedge tck) disable iff (!rst_n)
    ((state != S_UPD_IR) && (state != S_TLR)) |-> $stable(instr));

endmodule

// File: rtl/bscan_dr.sv
module bscan_dr
  import bscan_pkg::*;
#(
  parameter int          BSR_LEN = 109,
  parameter logic [31:0] ID_CODE = 32'h1E5A_C0B3
) (
  input  logic               tck,
  input  logic               rst_n,
  input  tap_state_e         state,
  input  dr_path_e           path,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pin_in,
  output logic               dr_lsb,
  output logic [BSR_LEN-1:0] ring_upd
);

  localparam int ID_LEN = 32;

  logic               byp_q, byp_nx;
  logic [ID_LEN-1:0]  id_q, id_nx;
  logic [BSR_LEN-1:0] bsr_q, bsr_nx;
  logic               cap_en, sh_en, upd_en;
  logic               sel_byp, sel_id, sel_bsr;

  assign cap_en  = (state == S_CAP_DR);
  assign sh_en   = (state == S_SH_DR);
  assign upd_en  = (state == S_UPD_DR);
  assign sel_byp = (path == PATH_BYP);
  assign sel_id  = (path == PATH_ID);
  assign sel_bsr = (path == PATH_BSR);

  always_comb begin
    byp_nx = byp_q;
    id_nx  = id_q;
    bsr_nx = bsr_q;
    if (sel_byp) begin
      if (cap_en)     byp_nx = 1'b0;
      else if (sh_en) byp_nx = tdi;
    end
    if (sel_id) begin
      if (cap_en)     id_nx = ID_CODE;
      else if (sh_en) id_nx = {tdi, id_q[ID_LEN-1:1]};
    end
    if (sel_bsr) begin
      if (cap_en)     bsr_nx = pin_in;
      else if (sh_en) bsr_nx = {tdi, bsr_q[BSR_LEN-1:1]};
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= 1'b0;
      id_q  <= '0;
      bsr_q <= '0;
    end else begin
      byp_q <= byp_nx;
      id_q  <= id_nx;
      bsr_q <= bsr_nx;
    end
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)                 ring_upd <= '0;
    else if (upd_en && sel_bsr) ring_upd <= bsr_q;
  end

  always_comb begin
    unique case (path)
      PATH_ID:  dr_lsb = id_q[0];
      PATH_BSR: dr_lsb = bsr_q[0];
      default:  dr_lsb = byp_q;
    endcase
  end

  // R8: bypass captures zero
  p_bypass_zero_r8: assert property (@(posedge tck) disable iff (!rst_n)
    ((state == S_CAP_DR) && sel_byp) |=> (byp_q == 1'b0));

  // R11: update latch only moves in Update-DR
  p_ring_hold_r11: assert property (@(posedge tck) disable iff (!rst_n)
    (state != S_UPD_DR) |-> $stable(ring_upd));

endmodule

// File: rtl/bscan_tap.sv
module bscan_tap
  import bscan_pkg::*;
#(
  parameter int          BSR_LEN = 109,
  parameter logic [31:0] ID_CODE = 32'h1E5A_C0B3
) (
  input  logic               tck,
  input  logic               por_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_oe,
  input  logic [BSR_LEN-1:0] pin_in,
  output logic [BSR_LEN-1:0] ring_upd,
  output logic               ring_oe,
  output logic               ring_extest
);

  // Reset asserts at once, releases on a rising tck edge.
  logic [1:0] rst_sync;
  logic       rst_n;
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  tap_state_e        state;
  logic              ir_lsb, dr_lsb;
  logic [IR_LEN-1:0] instr;
  dr_path_e          path;
  logic              op_extest, op_samplez;

  bscan_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .state (state)
  );

  bscan_ir u_ir (
    .tck        (tck),
    .rst_n      (rst_n),
    .state      (state),
    .tdi        (tdi),
    .ir_lsb     (ir_lsb),
    .instr      (instr),
    .path       (path),
    .op_extest  (op_extest),
    .op_samplez (op_samplez)
  );

  bscan_dr #(.BSR_LEN(BSR_LEN), .ID_CODE(ID_CODE)) u_dr (
    .tck      (tck),
    .rst_n    (rst_n),
    .state    (state),
    .path     (path),
    .tdi      (tdi),
    .pin_in   (pin_in),
    .dr_lsb   (dr_lsb),
    .ring_upd (ring_upd)
  );

  logic tdo_nx, tdo_oe_nx;
  always_comb begin
    tdo_oe_nx = (state == S_SH_IR) || (state == S_SH_DR);
    tdo_nx    = (state == S_SH_IR) ? ir_lsb : dr_lsb;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= tdo_nx;
      tdo_oe <= tdo_oe_nx;
    end
  end

  assign ring_oe     = !op_samplez;
  assign ring_extest = op_extest;

  // R2: output enabled only in a shift state
  p_tdo_en_r2: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe |-> ((state == S_SH_IR) || (state == S_SH_DR)));

endmodule

// File: tb/tb_bscan_tap.sv
`timescale 1ns/1ps
module tb_bscan_tap;
  localparam int          BSR_LEN = 109;
  localparam logic [31:0] ID_EXP  = 32'h1E5A_C0B3;

  logic tck = 1'b0;
  logic por_n, tms, tdi;
  logic tdo, tdo_oe, ring_oe, ring_extest;
  logic [BSR_LEN-1:0] pin_in, ring_upd;

  int n_chk = 0;
  int n_fail = 0;
  int glitches = 0;
  int cyc = 0;

  always #2 tck = ~tck;

  bscan_tap #(.BSR_LEN(BSR_LEN), .ID_CODE(ID_EXP)) dut (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .pin_in(pin_in), .ring_upd(ring_upd), .ring_oe(ring_oe), .ring_extest(ring_extest)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive after the falling edge, read tdo in the low phase, then confirm it
  // holds across the rising edge (R1).
  task automatic step(input logic m, input logic d, output logic o, output logic oe);
    @(negedge tck);
    #1;
    tms = m;
    tdi = d;
    o  = tdo;
    oe = tdo_oe;
    @(posedge tck);
    #1;
    if (tdo !== o) glitches++;
  endtask

  task automatic go(input logic m);
    logic o, oe;
    step(m, 1'b0, o, oe);
  endtask

  // From Run-Test-Idle back to Run-Test-Idle through Update-IR.
  task automatic scan_ir(input logic [2:0] code, output logic [2:0] cap);
    logic o, oe;
    go(1); go(1); go(0); go(0);
    for (int i = 0; i < 3; i++) begin
      step(i == 2, code[i], o, oe);
      cap[i] = o;
    end
    go(1); go(0);
  endtask

  // From Run-Test-Idle back to Run-Test-Idle through Update-DR.
  task automatic scan_dr(input int n, input logic [127:0] din,
                         output logic [127:0] dout, output int oe_ones);
    logic o, oe;
    dout = '0;
    oe_ones = 0;
    go(1); go(0); go(0);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], o, oe);
      dout[i] = o;
      if (oe) oe_ones++;
    end
    go(1); go(0);
  endtask

  task automatic t_reset;
    chk("R2 tdo_oe after reset", {127'd0, tdo_oe}, 128'd0);
    chk("R12 ring flags after reset", {126'd0, ring_oe, ring_extest}, 128'd2);
    go(0);
    chk("R2 tdo_oe in idle", {127'd0, tdo_oe}, 128'd0);
  endtask

  task automatic t_idcode;
    logic [127:0] q;
    int ones;
    glitches = 0;
    scan_dr(32, 128'h0, q, ones);
    chk("R4 R9 default instruction reads identity", q, {96'd0, ID_EXP});
    chk("R2 tdo_oe over shift", ones, 32);
    chk("R1 tdo steady across rising edge", glitches, 0);
    chk("R2 tdo_oe back in idle", {127'd0, tdo_oe}, 128'd0);
  endtask

  task automatic t_ir_capture;
    logic [2:0] cap;
    scan_ir(3'b111, cap);
    chk("R5 capture-IR pattern", {125'd0, cap}, 128'd1);
  endtask

  task automatic t_bypass;
    logic [127:0] q;
    logic [2:0] cap;
    int ones;
    logic [2:0] codes [4] = '{3'b111, 3'b011, 3'b101, 3'b110};
    foreach (codes[k]) begin
      scan_ir(codes[k], cap);
      scan_dr(8, 128'hB5, q, ones);
      chk("R7 R8 bypass path one bit, captures 0", q, 128'h6A);
    end
  endtask

  task automatic t_ir_hold;
    logic o, oe;
    go(1); go(1); go(0); go(0);
    step(0, 0, o, oe); step(0, 0, o, oe); step(1, 0, o, oe);
    go(0);
    @(negedge tck); #1;
    chk("R6 shifted code not active in Pause-IR", {127'd0, ring_extest}, 128'd0);
    go(1); go(1); go(0);
    chk("R6 R12 code active after Update-IR", {126'd0, ring_extest, ring_oe}, 128'd3);
  endtask

  task automatic t_extest;
    logic [127:0] q;
    logic [127:0] pat;
    int ones;
    pat = {19'd0, 109'h1A2B_3C4D_5E6F_7081_92A3_B4C5_D};
    pin_in = 109'h0F0F_F0F0_1234_5678_9ABC_DEF0_1;
    scan_dr(BSR_LEN, pat, q, ones);
    chk("R10 EXTEST captures pins", q, {19'd0, pin_in});
    chk("R11 EXTEST updates ring latch", {19'd0, ring_upd}, pat);
  endtask

  task automatic t_sample;
    logic [127:0] q;
    logic [2:0] cap;
    int ones;
    pin_in = 109'h1555_5555_5555_5555_5555_5555_5;
    scan_ir(3'b100, cap);
    chk("R12 SAMPLE flags", {126'd0, ring_extest, ring_oe}, 128'd1);
    scan_dr(BSR_LEN, 128'h3, q, ones);
    chk("R10 R7 SAMPLE captures 109 pins", q, {19'd0, pin_in});
    chk("R11 PRELOAD loads ring latch", {19'd0, ring_upd}, 128'h3);
  endtask

  task automatic t_samplez;
    logic [127:0] q;
    logic [2:0] cap;
    int ones;
    pin_in = {1'b1, 107'd0, 1'b1};
    scan_ir(3'b010, cap);
    chk("R12 SAMPLE-HIGHZ drivers off", {126'd0, ring_extest, ring_oe}, 128'd0);
    scan_dr(BSR_LEN, 128'h5, q, ones);
    chk("R10 SAMPLE-HIGHZ captures pins", q, {19'd0, pin_in});
  endtask

  task automatic t_no_update;
    logic [127:0] q;
    logic [2:0] cap;
    int ones;
    scan_ir(3'b001, cap);
    scan_dr(32, 128'hFFFF_FFFF, q, ones);
    chk("R11 IDCODE leaves ring latch", {19'd0, ring_upd}, 128'h5);
    scan_ir(3'b111, cap);
    scan_dr(4, 128'hF, q, ones);
    chk("R11 BYPASS leaves ring latch", {19'd0, ring_upd}, 128'h5);
  endtask

  task automatic t_tms_reset;
    logic [2:0] cap;
    scan_ir(3'b000, cap);
    chk("R12 EXTEST flag", {127'd0, ring_extest}, 128'd1);
    go(1); go(0); go(0);
    for (int i = 0; i < 5; i++) go(1);
    @(negedge tck); #1;
    chk("R3 R4 five high tms restores IDCODE", {127'd0, ring_extest}, 128'd0);
    chk("R3 tdo_oe off in reset state", {127'd0, tdo_oe}, 128'd0);
  endtask

  always @(posedge tck) begin
    cyc++;
    if (cyc > 50000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0;
    tms = 1'b1;
    tdi = 1'b0;
    pin_in = '0;
    repeat (4) @(posedge tck);
    #1 por_n = 1'b1;
    repeat (4) @(posedge tck);
    #1;
    t_reset;
    t_idcode;
    t_ir_capture;
    t_bypass;
    t_ir_hold;
    t_extest;
    t_sample;
    t_samplez;
    t_no_update;
    t_tms_reset;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule